// File: doc/BRIEF.md
# Processor Interrupt Control Unit

This block is the interrupt-decision logic of a small processor core. Up to `NUM_SRC` devices drive request lines into it. The unit holds four architectural registers:

- a processor status word, which carries a global interrupt-enable bit and the current priority level;
- a saved copy of that status word;
- a per-device enable mask;
- a per-device pending image.

At each instruction boundary it decides whether to enter an interrupt. Software reaches all four registers through a control-register move port. A single return input leaves a service routine.

When an interrupt is taken, the unit does the following in one step:

- copies the status word into the saved-status register;
- records the address of the next instruction;
- clears the enable bit;
- raises the current level to the level of the chosen device;
- sends a one-cycle acknowledge to that device;
- presents the handler address from a vector table at a fixed base.

If several enabled requests arrive together, a fixed priority picks one of them: the lowest device index wins. Device `k` sits at level `NUM_SRC-k`. It is accepted only while that level is strictly above the current level.

Top module: `irq_unit`

## Requirements
- R1: After reset, the status word, saved status, enable mask and pending image all read 0, and `irqTake` and `irqAck` are 0.
- R2: The pending image (select 3) shows `reqIn` as sampled at the previous clock edge. The bit of a device being acknowledged is cleared in that same edge. Writes to select 3 have no effect.
- R3: No interrupt is taken while the enable bit (status bit 0) is 0.
- R4: A device whose enable-mask bit is 0 is never selected.
- R5: An interrupt is taken only on an edge where `instrDone` is 1.
- R6: Among eligible devices, the lowest index is selected.
- R7: Device k is eligible only if NUM_SRC-k is greater than the current level (status bits [LVL_W:1]).
- R8: On entry, the old status word goes to the saved-status register. The new status has the enable bit at 0 and the level at NUM_SRC-k. `retPc` takes the value `nextPc` had on the entry edge.
- R9: `irqTake` is high for exactly the one cycle after the entry edge. In that same cycle `irqAck` is one-hot on the selected device; otherwise it is 0.
- R10: With `irqTake` high, `vecAddr` equals VEC_BASE + 4*k.
- R11: `rtiReq` copies the saved status into the status word. A return takes precedence over entry in the same cycle, and no entry happens in that cycle.
- R12: Control select 0 is the status word, 1 the saved status, 2 the enable mask and 3 the pending image. Reads are combinational and zero-extended. A write takes effect at the clock edge, but entry overrides writes to selects 0 and 1, and a return overrides a write to select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Device request lines |
| instrDone | input | 1 | Current instruction completes this cycle |
| nextPc | input | ADDR_W | Address of the following instruction |
| rtiReq | input | 1 | Return-from-interrupt strobe |
| ctlSel | input | 2 | Control register select |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | DATA_W | Control register write data |
| ctlRdData | output | DATA_W | Control register read data |
| irqTake | output | 1 | Interrupt entry pulse |
| irqAck | output | NUM_SRC | One-hot acknowledge to chosen device |
| vecAddr | output | ADDR_W | Handler address of last entry |
| retPc | output | ADDR_W | Saved return address |

## Verification
Several properties are checked on every cycle by assertions:

- every entry coincides with an instruction boundary and a set enable bit;
- no lower-index enabled pending device is passed over;
- the acknowledge is one-hot and matches the entry pulse;
- the enable bit is cleared and the old status saved after entry;
- a return restores the saved status.

The exact handler address, the recorded return address, the level comparison and the ordering of software writes against entry and return can only be shown by the bench's scenarios. The bench compares them against a cycle model, both in directed corner cases and in long random runs.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_PS   = 2'd0,
    SEL_IPS  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_PEND = 2'd3
  } ctlSel_e;

  typedef struct packed {
    logic take;
    logic rti;
    logic wrPs;
    logic wrIps;
    logic wrEn;
  } irqStrobe_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               found,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] oneHot
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (cand[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
    oneHot = found ? (NUM_SRC'(1) << idx) : '0;
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrDone,
  input  logic               rtiReq,
  input  logic               ctlWrEn,
  input  logic [1:0]         ctlSel,
  input  logic               psIe,
  input  logic [LVL_W-1:0]   psLvl,
  input  logic [NUM_SRC-1:0] enMask,
  input  logic [NUM_SRC-1:0] pendVec,
  output irqStrobe_t         strobe,
  output logic [IDX_W-1:0]   selIdx,
  output logic [NUM_SRC-1:0] selOneHot,
  output logic [LVL_W-1:0]   newLvl
);
  logic [NUM_SRC-1:0] eligible;
  logic               anyEligible;
  ctlSel_e            selDec;

  // each source compares its fixed level against the current one
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_elig
    localparam logic [LVL_W-1:0] SRC_LVL = LVL_W'(NUM_SRC - k);
    assign eligible[k] = pendVec[k] & enMask[k] & (SRC_LVL > psLvl);
  end

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .cand   (eligible),
    .found  (anyEligible),
    .idx    (selIdx),
    .oneHot (selOneHot)
  );

  always_comb begin
    selDec       = ctlSel_e'(ctlSel);
    newLvl       = LVL_W'(NUM_SRC) - LVL_W'(selIdx);
    strobe.rti   = rtiReq;
    strobe.take  = instrDone & psIe & anyEligible & ~rtiReq;
    strobe.wrPs  = ctlWrEn & (selDec == SEL_PS) & ~strobe.take & ~rtiReq;
    strobe.wrIps = ctlWrEn & (selDec == SEL_IPS) & ~strobe.take;
    strobe.wrEn  = ctlWrEn & (selDec == SEL_EN);
  end

  p_take_ie_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> psIe);
  p_take_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> instrDone);
  p_take_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> ((selOneHot & enMask) != '0));
  p_take_lowest_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> ((pendVec & enMask & (selOneHot - 1'b1)) == '0));
  p_rti_blocks_take_r11: assert property (@(posedge clk) disable iff (!rstN)
    rtiReq |-> !strobe.take);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int              NUM_SRC  = 8,
  parameter int              LVL_W    = 4,
  parameter int              IDX_W    = 3,
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [IDX_W-1:0]   selIdx,
  input  logic [NUM_SRC-1:0] selOneHot,
  input  logic [LVL_W-1:0]   newLvl,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic [1:0]         ctlSel,
  input  logic [DATA_W-1:0]  ctlWrData,
  output logic [DATA_W-1:0]  ctlRdData,
  output logic               psIe,
  output logic [LVL_W-1:0]   psLvl,
  output logic [NUM_SRC-1:0] enMask,
  output logic [NUM_SRC-1:0] pendVec,
  output logic               irqTake,
  output logic [NUM_SRC-1:0] irqAck,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [ADDR_W-1:0]  retPc
);
  localparam int PS_W = LVL_W + 1;

  logic [PS_W-1:0]    psReg, ipsReg;
  logic [NUM_SRC-1:0] enReg, pendReg, ackQ;
  logic [ADDR_W-1:0]  epcReg, vecQ;
  logic               takeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psReg   <= '0;
      ipsReg  <= '0;
      enReg   <= '0;
      pendReg <= '0;
      epcReg  <= '0;
      vecQ    <= '0;
      takeQ   <= 1'b0;
      ackQ    <= '0;
    end else begin
      pendReg <= reqIn & ~(strobe.take ? selOneHot : '0);
      if (strobe.rti)       psReg <= ipsReg;
      else if (strobe.take) psReg <= {newLvl, 1'b0};
      else if (strobe.wrPs) psReg <= ctlWrData[PS_W-1:0];
      if (strobe.take)       ipsReg <= psReg;
      else if (strobe.wrIps) ipsReg <= ctlWrData[PS_W-1:0];
      if (strobe.wrEn) enReg <= ctlWrData[NUM_SRC-1:0];
      takeQ <= strobe.take;
      ackQ  <= strobe.take ? selOneHot : '0;
      if (strobe.take) begin
        epcReg <= nextPc;
        vecQ   <= VEC_BASE + (ADDR_W'(selIdx) << 2);
      end
    end
  end

  always_comb begin
    case (ctlSel_e'(ctlSel))
      SEL_PS:  ctlRdData = DATA_W'(psReg);
      SEL_IPS: ctlRdData = DATA_W'(ipsReg);
      SEL_EN:  ctlRdData = DATA_W'(enReg);
      default: ctlRdData = DATA_W'(pendReg);
    endcase
  end

  assign psIe    = psReg[0];
  assign psLvl   = psReg[PS_W-1:1];
  assign enMask  = enReg;
  assign pendVec = pendReg;
  assign irqTake = takeQ;
  assign irqAck  = ackQ;
  assign vecAddr = vecQ;
  assign retPc   = epcReg;

  p_entry_save_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (!psReg[0] && ipsReg == $past(psReg) && epcReg == $past(nextPc)));
  p_rti_restore_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rti |=> psReg == $past(ipsReg));
  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackQ) && (takeQ == (ackQ != '0)));
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter int                NUM_SRC  = 8,
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               instrDone,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic               rtiReq,
  input  logic [1:0]         ctlSel,
  input  logic               ctlWrEn,
  input  logic [DATA_W-1:0]  ctlWrData,
  output logic [DATA_W-1:0]  ctlRdData,
  output logic               irqTake,
  output logic [NUM_SRC-1:0] irqAck,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [ADDR_W-1:0]  retPc
);
  localparam int LVL_W = $clog2(NUM_SRC + 1);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  irqStrobe_t         strobe;
  logic [IDX_W-1:0]   selIdx;
  logic [NUM_SRC-1:0] selOneHot, enMask, pendVec;
  logic [LVL_W-1:0]   newLvl, psLvl;
  logic               psIe;

  irq_control #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk, .rstN, .instrDone, .rtiReq, .ctlWrEn, .ctlSel,
    .psIe, .psLvl, .enMask, .pendVec,
    .strobe, .selIdx, .selOneHot, .newLvl
  );

  irq_datapath #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)
  ) u_dp (
    .clk, .rstN, .strobe, .selIdx, .selOneHot, .newLvl,
    .reqIn, .nextPc, .ctlSel, .ctlWrData, .ctlRdData,
    .psIe, .psLvl, .enMask, .pendVec,
    .irqTake, .irqAck, .vecAddr, .retPc
  );
endmodule

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
  localparam int          N    = 8;
  localparam int          AW   = 32;
  localparam int          DW   = 32;
  localparam logic [31:0] BASE = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rstN;
  logic [N-1:0]  reqIn;
  logic          instrDone, rtiReq, ctlWrEn;
  logic [AW-1:0] nextPc;
  logic [1:0]    ctlSel;
  logic [DW-1:0] ctlWrData, ctlRdData;
  logic          irqTake;
  logic [N-1:0]  irqAck;
  logic [AW-1:0] vecAddr, retPc;

  always #10 clk = ~clk;

  irq_unit #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW), .VEC_BASE(BASE)) u_irq_unit (
    .clk, .rstN, .reqIn, .instrDone, .nextPc, .rtiReq, .ctlSel, .ctlWrEn,
    .ctlWrData, .ctlRdData, .irqTake, .irqAck, .vecAddr, .retPc
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state
  logic [4:0]    mPs, mIps;
  logic [N-1:0]  mEn, mPend, mAck, devReq;
  logic [AW-1:0] mEpc, mVec;
  logic          mTake;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] modelRead(input logic [1:0] s);
    case (s)
      2'd0: return DW'(mPs);
      2'd1: return DW'(mIps);
      2'd2: return DW'(mEn);
      default: return DW'(mPend);
    endcase
  endfunction

  // returns index of chosen source, or -1
  function automatic int modelPick();
    for (int k = 0; k < N; k++)
      if (mPend[k] && mEn[k] && ((N - k) > int'(mPs[4:1]))) return k;
    return -1;
  endfunction

  // one clock: entered and left at a falling edge
  task automatic cycle(input bit done, input bit rti, input logic [1:0] sel,
                       input bit we, input logic [DW-1:0] wd,
                       input logic [N-1:0] newReq, input string tag);
    int k;
    bit take;
    logic [4:0] nPs, nIps;
    devReq    = (devReq & ~mAck) | newReq;
    reqIn     = devReq;
    instrDone = done;
    rtiReq    = rti;
    ctlSel    = sel;
    ctlWrEn   = we;
    ctlWrData = wd;
    nextPc    = $urandom;
    #1;
    check(ctlRdData == modelRead(sel), tag, "read", ctlRdData, modelRead(sel));
    k    = modelPick();
    take = done && mPs[0] && (k >= 0) && !rti;
    nPs  = mPs;
    nIps = mIps;
    if (rti) nPs = mIps;
    else if (take) nPs = {4'(N - k), 1'b0};
    else if (we && sel == 2'd0) nPs = wd[4:0];
    if (take) nIps = mPs;
    else if (we && sel == 2'd1) nIps = wd[4:0];
    if (we && sel == 2'd2) mEn = wd[N-1:0];
    mPend = reqIn & ~(take ? N'(1) << k : N'(0));
    mPs   = nPs;
    mIps  = nIps;
    mTake = take;
    mAck  = take ? N'(1) << k : N'(0);
    if (take) begin
      mEpc = nextPc;
      mVec = BASE + 32'(4 * k);
    end
    @(posedge clk);
    @(negedge clk);
    check(irqTake == mTake, tag, "irqTake", irqTake, mTake);
    check(irqAck == mAck, tag, "irqAck", irqAck, mAck);
    check(retPc == mEpc, tag, "retPc", retPc, mEpc);
    if (mTake) check(vecAddr == mVec, tag, "vecAddr", vecAddr, mVec);
  endtask

  task automatic peek(input logic [1:0] sel, input logic [DW-1:0] exp, input string tag);
    ctlSel = sel;
    ctlWrEn = 1'b0;
    #1;
    check(ctlRdData == exp, tag, "reg", ctlRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!finished) begin
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad_5eed));
    rstN = 0; reqIn = '0; instrDone = 0; rtiReq = 0; ctlWrEn = 0;
    ctlSel = 0; ctlWrData = '0; nextPc = '0;
    mPs = 0; mIps = 0; mEn = 0; mPend = 0; mAck = 0; mEpc = 0; mVec = 0;
    mTake = 0; devReq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    peek(2'd0, 0, "R1"); peek(2'd1, 0, "R1"); peek(2'd2, 0, "R1"); peek(2'd3, 0, "R1");
    check(irqTake == 0 && irqAck == 0, "R1", "outputs", {irqTake, irqAck}, 0);
    // R12 register writes
    cycle(0, 0, 2'd2, 1, 32'hFF, 0, "R12");
    peek(2'd2, 32'hFF, "R12");
    cycle(0, 0, 2'd1, 1, 32'h0B, 0, "R12");
    peek(2'd1, 32'h0B, "R12");
    // R2 pending image: write ignored, follows requests
    cycle(0, 0, 2'd3, 1, 32'hFF, 0, "R2");
    peek(2'd3, 0, "R2");
    cycle(1, 0, 2'd3, 0, 0, 8'h04, "R3");   // IE still 0: no entry
    peek(2'd3, 32'h04, "R2");
    cycle(1, 0, 2'd0, 0, 0, 0, "R3");
    // enable, level 0
    cycle(0, 0, 2'd0, 1, 32'h01, 0, "R12");
    // R5 no boundary
    cycle(0, 0, 2'd0, 0, 0, 0, "R5");
    cycle(0, 0, 2'd0, 0, 0, 0, "R5");
    // R6 take device 2 (already pending) plus newer higher-index request
    cycle(1, 0, 2'd0, 0, 0, 8'h40, "R6");
    cycle(0, 0, 2'd0, 0, 0, 0, "R9");
    peek(2'd0, 32'((N - 2) << 1), "R8");
    peek(2'd1, 32'h01, "R8");
    // R11 return restores status
    cycle(0, 1, 2'd0, 0, 0, 0, "R11");
    peek(2'd0, 32'h01, "R11");
    // R4 disable device 6 then try
    cycle(0, 0, 2'd2, 1, 32'hBF, 0, "R4");
    cycle(1, 0, 2'd0, 0, 0, 0, "R4");
    cycle(1, 0, 2'd0, 0, 0, 0, "R4");
    cycle(0, 0, 2'd2, 1, 32'hFF, 0, "R12");
    // R7 level 3: device 5 (level 3) refused, device 4 accepted
    cycle(0, 0, 2'd0, 1, 32'h07, 8'h20, "R7");
    cycle(1, 0, 2'd0, 0, 0, 0, "R7");
    cycle(1, 0, 2'd0, 0, 0, 8'h10, "R7");
    cycle(1, 0, 2'd0, 0, 0, 0, "R10");
    // R11 return and entry in the same cycle
    cycle(0, 0, 2'd1, 1, 32'h01, 0, "R12");
    cycle(1, 1, 2'd0, 0, 0, 8'h01, "R11");
    cycle(1, 0, 2'd0, 0, 0, 0, "R10");
    cycle(0, 1, 2'd0, 0, 0, 0, "R11");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] nr;
      nr = ($urandom % 4 == 0) ? N'($urandom) & N'($urandom) : '0;
      cycle(($urandom % 2) == 1, ($urandom % 16) == 0, 2'($urandom),
            ($urandom % 6) == 0, (($urandom % 3) == 0) ? 32'h01 : $urandom,
            nr, "RND");
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule